// File: doc/BRIEF.md
# Delta-Modulation Sample Channel

This block plays back a stream of 1-bit delta-coded audio. It reads sample bytes from memory through a request/valid port and spends them one bit per timer expiry, most significant bit first. A one-bit raises a 7-bit output level by two and a zero-bit lowers it by two. A step that would leave the 0..127 range is refused, so the level never wraps. The timer period comes from a 16-entry rate table, and software can load the level directly at any time.

The sample start address and byte count are derived from two 8-bit registers by fixed formulas. When the sample runs out, the channel can restart it from the start address, or it can stop and raise an interrupt flag. A status output shows whether bytes remain to be fetched. The channel is controlled through four register slots and a separate enable write. While a memory fetch is outstanding, the timer and the level are frozen.

Top module: `delta_sample_voice`

## Requirements
- R1: After reset the level is 0, and `irq`, `active` and `mem_req` are 0.
- R2: A write to slot 0 (`wr_sel`=0) sets the rate from `wr_data[3:0]`. The index selects a period in cycles from the table 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54 (index 0 first). The timer counts only while the channel is enabled. The first fetch request appears exactly one period after the enabling write.
- R3: A write to slot 2 stores an 8-bit base B and sets the fetch address to (B | 0x300) << 6. Each request presents the address with bit 15 set on `mem_addr`, and the address advances by one after each accepted byte.
- R4: The remaining byte count is reloaded as 16 × L + 1, where L is the 8-bit value written to slot 3. `active` is 1 exactly while the count is nonzero, and each accepted byte decrements it.
- R5: The bits of a byte are consumed MSB first. The bit in position 7 is applied in the cycle the byte is accepted, and each later bit is applied on a timer expiry. A 1 adds 2 to the level and a 0 subtracts 2.
- R6: A step whose result would be above 127 or below 0 is discarded, and the level is left unchanged.
- R7: A write to slot 1 loads `wr_data[6:0]` into the level on the next cycle. Bit 7 is ignored.
- R8: Bit 6 of slot 0 selects looping. A timer expiry with no bits left and a count of 0 then reloads the address and count and starts a new fetch.
- R9: Bit 7 of slot 0 enables the interrupt. Without looping, an expiry with no bits left and a count of 0 sets `irq` if the interrupt is enabled, and disables the channel in either case, so that no further fetch happens. `irq` is cleared by any write to slot 0 with bit 7 clear and by any enable write.
- R10: An enable write of 0 clears the count. An enable write of 1 while the count is 0 reloads the address and count and discards any buffered bits.
- R11: A write to slot 3 while the count is 0 reloads the count at once, even when the channel is disabled.
- R12: While `mem_req` is high and `mem_valid` is low, `mem_req`, `mem_addr` and the level hold their values and the timer does not advance. The next step falls one full period after the byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Slot: 0 rate/flags, 1 direct level, 2 base address, 3 length |
| wr_data | input | 8 | Write data |
| en_wr | input | 1 | Channel-enable write strobe |
| en_val | input | 1 | Enable value written |
| mem_req | output | 1 | Fetch request, held until accepted |
| mem_addr | output | 16 | Fetch address |
| mem_valid | input | 1 | Fetch data valid; accepts the request |
| mem_data | input | 8 | Fetched byte |
| level | output | 7 | Output level |
| active | output | 1 | Remaining byte count is nonzero |
| irq | output | 1 | End-of-sample interrupt flag |

## Verification
A register write shows at the outputs one cycle after the edge that samples it. The first request after an enabling write appears exactly one rate period later. The first step of a byte lands on the edge that accepts it. Each later step, and the end-of-sample decision, follows one period after the previous one, with a fetch wait adding exactly its own length. The bench drives on falling edges and then counts falling edges to these points. It measures the period by counting edges until the request rises, and it checks the level, the count status and the flag only at the computed edge.

// File: rtl/dsv_pkg.sv
package dsv_pkg;

  typedef enum logic {
    DSV_IDLE  = 1'b0,
    DSV_FETCH = 1'b1
  } dsv_state_e;

  // Timer period in cycles for each rate index.
  function automatic logic [11:0] dsv_period(input logic [3:0] idx);
    logic [11:0] p;
    case (idx)
      4'd0:    p = 12'd428;
      4'd1:    p = 12'd380;
      4'd2:    p = 12'd340;
      4'd3:    p = 12'd320;
      4'd4:    p = 12'd286;
      4'd5:    p = 12'd254;
      4'd6:    p = 12'd226;
      4'd7:    p = 12'd214;
      4'd8:    p = 12'd190;
      4'd9:    p = 12'd160;
      4'd10:   p = 12'd142;
      4'd11:   p = 12'd128;
      4'd12:   p = 12'd106;
      4'd13:   p = 12'd84;
      4'd14:   p = 12'd72;
      default: p = 12'd54;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/dsv_rate_timer.sv
module dsv_rate_timer
  import dsv_pkg::*;
#(
  parameter int TMR_W = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rate_wr,
  input  logic [3:0] rate_idx,
  input  logic       run,
  input  logic       park,
  output logic       tick
);

  logic [TMR_W-1:0] reload_q, reload_d;
  logic [TMR_W-1:0] ctr_q, ctr_d;
  logic             ctr_ce;

  always_comb begin
    reload_d = reload_q;
    if (rate_wr) begin
      reload_d = TMR_W'(dsv_period(rate_idx) - 12'd1);
    end
  end

  always_comb begin
    ctr_d  = ctr_q;
    ctr_ce = 1'b0;
    tick   = 1'b0;
    if (park) begin
      ctr_d  = reload_q;
      ctr_ce = 1'b1;
    end else if (run) begin
      ctr_ce = 1'b1;
      if (ctr_q == '0) begin
        tick  = 1'b1;
        ctr_d = reload_q;
      end else begin
        ctr_d = ctr_q - TMR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= TMR_W'(dsv_period(4'd0) - 12'd1);
      ctr_q    <= '0;
    end else begin
      if (rate_wr) reload_q <= reload_d;
      if (ctr_ce)  ctr_q    <= ctr_d;
    end
  end

endmodule

// File: rtl/dsv_level_acc.sv
module dsv_level_acc #(
  parameter int LVL_W = 7,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LVL_W-1:0] load_val,
  input  logic             bit_stb,
  input  logic             bit_val,
  output logic [LVL_W-1:0] level
);

  localparam int LVL_MAX = (1 << LVL_W) - 1;

  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             lvl_ce;
  logic             can_up, can_down;

  assign can_up   = (int'(lvl_q) <= (LVL_MAX - STEP));
  assign can_down = (int'(lvl_q) >= STEP);

  always_comb begin
    lvl_d  = lvl_q;
    lvl_ce = 1'b0;
    if (load) begin
      lvl_d  = load_val;
      lvl_ce = 1'b1;
    end else if (bit_stb) begin
      if (bit_val && can_up) begin
        lvl_d  = lvl_q + LVL_W'(STEP);
        lvl_ce = 1'b1;
      end else if (!bit_val && can_down) begin
        lvl_d  = lvl_q - LVL_W'(STEP);
        lvl_ce = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (lvl_ce) begin
      lvl_q <= lvl_d;
    end
  end

  assign level = lvl_q;

endmodule

// File: rtl/dsv_fetch_ctrl.sv
module dsv_fetch_ctrl
  import dsv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int AREG_W = 8,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_wr,
  input  logic              cfg_irq_en,
  input  logic              cfg_loop,
  input  logic              base_wr,
  input  logic [AREG_W-1:0] base_val,
  input  logic              len_wr,
  input  logic [LEN_W-1:0]  len_val,
  input  logic              en_wr,
  input  logic              en_val,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data,
  output logic              bit_stb,
  output logic              bit_val,
  output logic              active,
  output logic              irq,
  output logic              enabled,
  output logic              busy
);

  localparam int CNT_W = LEN_W + 4;
  localparam int SHL   = ADDR_W - AREG_W - 2;
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [ADDR_W-1:0] FETCH_MASK = ADDR_W'(1) << (ADDR_W - 1);

  dsv_state_e        st_q, st_d;
  logic              en_q, en_d;
  logic              irq_q, irq_d;
  logic              irqen_q, irqen_d;
  logic              loop_q, loop_d;
  logic [AREG_W-1:0] base_q, base_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic [BIT_W-1:0]  bits_q, bits_d;

  logic [ADDR_W-1:0] start_cur, start_new;
  logic [CNT_W-1:0]  reload_cur, reload_new;

  assign start_cur  = ADDR_W'({2'b11, base_q}) << SHL;
  assign start_new  = ADDR_W'({2'b11, base_val}) << SHL;
  assign reload_cur = CNT_W'({len_q, 4'b0000}) + CNT_W'(1);
  assign reload_new = CNT_W'({len_val, 4'b0000}) + CNT_W'(1);

  always_comb begin
    st_d    = st_q;
    en_d    = en_q;
    irq_d   = irq_q;
    irqen_d = irqen_q;
    loop_d  = loop_q;
    base_d  = base_q;
    len_d   = len_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    shf_d   = shf_q;
    bits_d  = bits_q;
    bit_stb = 1'b0;
    bit_val = 1'b0;

    // Playback sequencing.
    if (st_q == DSV_FETCH) begin
      if (mem_valid) begin
        bit_stb = 1'b1;
        bit_val = mem_data[DATA_W-1];
        shf_d   = {mem_data[DATA_W-2:0], 1'b0};
        bits_d  = BIT_W'(DATA_W - 1);
        addr_d  = addr_q + ADDR_W'(1);
        if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
        st_d    = DSV_IDLE;
      end
    end else if (tick) begin
      if (bits_q == '0) begin
        if (cnt_q == '0 && loop_q) begin
          addr_d = start_cur;
          cnt_d  = reload_cur;
        end
        if (cnt_q != '0 || loop_q) begin
          st_d = DSV_FETCH;
        end else begin
          if (irqen_q) irq_d = 1'b1;
          en_d = 1'b0;
        end
      end else begin
        bit_stb = 1'b1;
        bit_val = shf_q[DATA_W-1];
        shf_d   = {shf_q[DATA_W-2:0], 1'b0};
        bits_d  = bits_q - BIT_W'(1);
      end
    end

    // Register writes take priority over sequencing.
    if (cfg_wr) begin
      irqen_d = cfg_irq_en;
      loop_d  = cfg_loop;
      if (!cfg_irq_en) irq_d = 1'b0;
    end
    if (base_wr) begin
      base_d = base_val;
      addr_d = start_new;
    end
    if (len_wr) begin
      len_d = len_val;
      if (cnt_q == '0) cnt_d = reload_new;
    end
    if (en_wr) begin
      irq_d = 1'b0;
      en_d  = en_val;
      if (!en_val) begin
        cnt_d = '0;
      end else if (cnt_q == '0) begin
        addr_d = start_cur;
        cnt_d  = reload_cur;
        bits_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= DSV_IDLE;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
      irqen_q <= 1'b0;
      loop_q  <= 1'b0;
      base_q  <= '0;
      len_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      shf_q   <= '0;
      bits_q  <= '0;
    end else begin
      st_q    <= st_d;
      en_q    <= en_d;
      irq_q   <= irq_d;
      irqen_q <= irqen_d;
      loop_q  <= loop_d;
      base_q  <= base_d;
      len_q   <= len_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      if (bit_stb) shf_q <= shf_d;
      bits_q  <= bits_d;
    end
  end

  assign mem_req  = (st_q == DSV_FETCH);
  assign busy     = (st_q == DSV_FETCH);
  assign mem_addr = addr_q | FETCH_MASK;
  assign active   = (cnt_q != '0);
  assign irq      = irq_q;
  assign enabled  = en_q;

endmodule

// File: rtl/delta_sample_voice.sv
module delta_sample_voice
  import dsv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int AREG_W = 8,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 7,
  parameter int STEP   = 2,
  parameter int TMR_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              en_wr,
  input  logic              en_val,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data,
  output logic [LVL_W-1:0]  level,
  output logic              active,
  output logic              irq
);

  // Reset asserts at once and releases on a clock edge.
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic sel_cfg, sel_lvl, sel_base, sel_len;
  assign sel_cfg  = wr_en && (wr_sel == 2'd0);
  assign sel_lvl  = wr_en && (wr_sel == 2'd1);
  assign sel_base = wr_en && (wr_sel == 2'd2);
  assign sel_len  = wr_en && (wr_sel == 2'd3);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^wr_data[5:4];

  logic tick, bit_stb, bit_val, enabled, busy;

  dsv_rate_timer #(
    .TMR_W(TMR_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (srst_n),
    .rate_wr (sel_cfg),
    .rate_idx(wr_data[3:0]),
    .run     (enabled && !busy),
    .park    (!enabled),
    .tick    (tick)
  );

  dsv_fetch_ctrl #(
    .ADDR_W(ADDR_W),
    .AREG_W(AREG_W),
    .LEN_W (LEN_W),
    .DATA_W(DATA_W)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (srst_n),
    .tick      (tick),
    .cfg_wr    (sel_cfg),
    .cfg_irq_en(wr_data[7]),
    .cfg_loop  (wr_data[6]),
    .base_wr   (sel_base),
    .base_val  (wr_data[AREG_W-1:0]),
    .len_wr    (sel_len),
    .len_val   (wr_data[LEN_W-1:0]),
    .en_wr     (en_wr),
    .en_val    (en_val),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid),
    .mem_data  (mem_data),
    .bit_stb   (bit_stb),
    .bit_val   (bit_val),
    .active    (active),
    .irq       (irq),
    .enabled   (enabled),
    .busy      (busy)
  );

  dsv_level_acc #(
    .LVL_W(LVL_W),
    .STEP (STEP)
  ) u_level (
    .clk     (clk),
    .rst_n   (srst_n),
    .load    (sel_lvl),
    .load_val(wr_data[LVL_W-1:0]),
    .bit_stb (bit_stb),
    .bit_val (bit_val),
    .level   (level)
  );

endmodule

// File: rtl/dsv_checker.sv
module dsv_checker #(
  parameter int ADDR_W = 16,
  parameter int LVL_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [LVL_W-1:0]  dl_val,
  input logic              en_wr,
  input logic              en_val,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_valid,
  input logic [LVL_W-1:0]  level,
  input logic              active,
  input logic              irq
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic lvl_wr, base_wr;
  assign lvl_wr  = wr_en && (wr_sel == 2'd1);
  assign base_wr = wr_en && (wr_sel == 2'd2);

  // R5
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !lvl_wr) |=> (level == $past(level) ||
                              32'(level) == 32'($past(level)) + 2 ||
                              32'(level) + 2 == 32'($past(level))));

  // R7
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && lvl_wr) |=> (level == $past(dl_val)));

  // R12
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mem_req && !mem_valid && !lvl_wr) |=> (level == $past(level)));

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mem_req && !mem_valid && !base_wr) |=> (mem_req && $stable(mem_addr)));

  // R10
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && en_wr && !en_val) |=> (!active && !irq));

  // R9
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && en_wr) |=> !irq);

endmodule

bind delta_sample_voice dsv_checker #(
  .ADDR_W(ADDR_W),
  .LVL_W (LVL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .dl_val   (wr_data[LVL_W-1:0]),
  .en_wr    (en_wr),
  .en_val   (en_val),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .mem_valid(mem_valid),
  .level    (level),
  .active   (active),
  .irq      (irq)
);

// File: tb/delta_sample_voice_bench.sv
`timescale 1ns/1ps
module delta_sample_voice_bench;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [7:0]  wr_data;
  logic        en_wr;
  logic        en_val;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_valid;
  logic [7:0]  mem_data;
  logic [6:0]  level;
  logic        active;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int mem_lat = 0;
  int wait_cnt = 0;
  logic [7:0] mem_byte = 8'h00;

  delta_sample_voice u_delta_sample_voice (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .en_wr    (en_wr),
    .en_val   (en_val),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_valid(mem_valid),
    .mem_data (mem_data),
    .level    (level),
    .active   (active),
    .irq      (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Memory responder: answers mem_lat falling edges after the request is seen.
  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid <= 1'b0;
    end else if (mem_req) begin
      if (wait_cnt == mem_lat) begin
        mem_valid <= 1'b1;
        mem_data  <= mem_byte;
        wait_cnt  <= 0;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int step(input int lv, input bit b);
    if (b) return (lv + 2 <= 127) ? lv + 2 : lv;
    return (lv - 2 >= 0) ? lv - 2 : lv;
  endfunction

  task automatic reg_wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic en_write(input logic v);
    @(negedge clk);
    en_wr = 1'b1; en_val = v;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!mem_req && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Called at the falling edge where the request is first seen.
  task automatic play_byte(input logic [7:0] b, input int lat, input int per,
                           inout int lv, input string req);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      check(mem_req == 1'b1, "R12 request held", int'(mem_req), 1);
      check(int'(level) == lv, "R12 level held during fetch", int'(level), lv);
    end
    @(negedge clk);
    lv = step(lv, b[7]);
    check(int'(level) == lv, req, int'(level), lv);
    for (int k = 6; k >= 0; k--) begin
      repeat (per) @(negedge clk);
      lv = step(lv, b[k]);
      check(int'(level) == lv, req, int'(level), lv);
    end
  endtask

  task automatic quiet_window(input int lv, input string req);
    bit seen_req = 1'b0;
    bit moved    = 1'b0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (mem_req) seen_req = 1'b1;
      if (int'(level) != lv) moved = 1'b1;
    end
    check(!seen_req && !moved, req, int'(seen_req), 0);
  endtask

  task automatic t_reset();
    check(level == 7'd0, "R1 level", int'(level), 0);
    check(irq == 1'b0, "R1 irq", int'(irq), 0);
    check(active == 1'b0, "R1 active", int'(active), 0);
    check(mem_req == 1'b0, "R1 mem_req", int'(mem_req), 0);
  endtask

  task automatic t_direct();
    reg_wr(2'd1, 8'hC0);
    check(level == 7'h40, "R7 direct level", int'(level), 'h40);
  endtask

  task automatic t_basic();
    int n;
    int lv = 64;
    reg_wr(2'd0, 8'h0F);
    reg_wr(2'd2, 8'h01);
    reg_wr(2'd3, 8'h00);
    check(active == 1'b1, "R11 length reload while count zero", int'(active), 1);
    mem_byte = 8'hF4;
    mem_lat  = 3;
    en_write(1'b1);
    wait_req(n);
    check(n == 54, "R2 period index 15", n, 54);
    check(mem_addr == 16'hC040, "R3 start address", int'(mem_addr), 'hC040);
    play_byte(8'hF4, 3, 54, lv, "R5 msb-first steps");
    repeat (54) @(negedge clk);
    check(active == 1'b0, "R4 count 16*0+1 used up", int'(active), 0);
    check(irq == 1'b0, "R9 no irq when disabled", int'(irq), 0);
    quiet_window(lv, "R9 channel stops after end");
  endtask

  task automatic t_rate_clamp_high();
    int n;
    int lv = 123;
    mem_lat = 0;
    reg_wr(2'd0, 8'h0E);
    reg_wr(2'd1, 8'd123);
    reg_wr(2'd3, 8'h00);
    check(active == 1'b1, "R4 count reloaded", int'(active), 1);
    mem_byte = 8'hFF;
    en_write(1'b1);
    wait_req(n);
    check(n == 72, "R2 period index 14", n, 72);
    check(mem_addr == 16'hC041, "R3 address advanced", int'(mem_addr), 'hC041);
    play_byte(8'hFF, 0, 72, lv, "R6 upper clamp");
    check(level == 7'd127, "R6 level pinned at 127", int'(level), 127);
    repeat (72) @(negedge clk);
  endtask

  task automatic t_irq(input bit clear_by_rate);
    int n;
    int lv = 3;
    mem_lat = 0;
    reg_wr(2'd0, 8'h8F);
    reg_wr(2'd2, 8'h02);
    reg_wr(2'd1, 8'd3);
    mem_byte = 8'h00;
    en_write(1'b1);
    check(active == 1'b1, "R10 enable reloads count", int'(active), 1);
    wait_req(n);
    check(n == 54, "R2 period after reload", n, 54);
    check(mem_addr == 16'hC080, "R10 enable reloads address", int'(mem_addr), 'hC080);
    play_byte(8'h00, 0, 54, lv, "R6 lower clamp");
    check(level == 7'd1, "R6 level pinned at 1", int'(level), 1);
    repeat (54) @(negedge clk);
    check(irq == 1'b1, "R9 irq raised at end", int'(irq), 1);
    reg_wr(2'd0, 8'h8F);
    check(irq == 1'b1, "R9 rate write with bit7 set keeps irq", int'(irq), 1);
    if (clear_by_rate) begin
      reg_wr(2'd0, 8'h0F);
      check(irq == 1'b0, "R9 rate write bit7 clear drops irq", int'(irq), 0);
    end else begin
      en_write(1'b0);
      check(irq == 1'b0, "R9 enable write drops irq", int'(irq), 0);
    end
  endtask

  task automatic t_loop();
    int n;
    int lv = 20;
    mem_lat = 0;
    reg_wr(2'd0, 8'h4F);
    reg_wr(2'd2, 8'h03);
    reg_wr(2'd1, 8'd20);
    mem_byte = 8'h0F;
    en_write(1'b1);
    wait_req(n);
    check(mem_addr == 16'hC0C0, "R3 base 3 address", int'(mem_addr), 'hC0C0);
    play_byte(8'h0F, 0, 54, lv, "R5 zero bits then one bits");
    repeat (54) @(negedge clk);
    check(mem_req == 1'b1, "R8 loop restarts fetch", int'(mem_req), 1);
    check(mem_addr == 16'hC0C0, "R8 loop reloads address", int'(mem_addr), 'hC0C0);
    check(active == 1'b1, "R8 loop reloads count", int'(active), 1);
    @(negedge clk);
    lv = step(lv, 1'b0);
    en_write(1'b0);
    check(active == 1'b0, "R10 disable clears count", int'(active), 0);
    quiet_window(lv, "R10 disabled channel idle");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'h00;
    en_wr = 1'b0; en_val = 1'b0; mem_valid = 1'b0; mem_data = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_direct();
    t_basic();
    t_rate_clamp_high();
    t_irq(1'b0);
    t_irq(1'b1);
    t_loop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule